// File: doc/BRIEF.md
# Prescaled Down-Counting Core Timer

This block is a 32-bit system tick timer that sits behind a small word-addressed register port. Software loads a period, picks a prescale divisor and then turns the timer on by setting two independent control bits, one for power and one for enable. While both are set, a prescaler divides the input clock and each prescaler step lowers the count by one. When the count runs out, the timer latches a sticky interrupt flag in its control word and drives a one-cycle interrupt pulse.

After expiry the timer either reloads the count from the period register and keeps going, or it parks with the count at zero until software turns it off and on again. The period and count can be rewritten at any moment, and a period write also loads the count. The divisor can be changed on the fly without losing the count already consumed. Accesses that are not full aligned words are refused and flagged.

Top module: `core_tick_timer`

## Requirements
- R1: Registers sit at word offsets control 0x0, period 0x4, scale 0x8, count 0xC. Control bits are: bit 0 power, bit 1 enable, bit 2 auto-reload, bit 3 interrupt flag; control bits 31..4 always read as zero and are not stored.
- R2: Only aligned accesses with bus_size = 2 (word; 0 is byte, 1 is halfword) are accepted. Any other size or a nonzero bus_addr[1:0] raises bus_err in the same cycle, writes nothing and returns zero read data.
- R3: The timer counts only while both power and enable are set; with either clear the count and the interrupt output stay still.
- R4: Each count step takes scale[7:0] + 1 clock cycles; scale bits 31..8 have no effect. From the clock edge that starts the timer with count N and divisor D, expiry happens at the edge N*D cycles later.
- R5: On expiry the flag (control bit 3) is set and tmr_irq is high for exactly one cycle, the same cycle in which the flag is first seen set.
- R6: With auto-reload set, expiry loads the count from the period register and the next expiry follows period*D cycles later.
- R7: With auto-reload clear, expiry leaves the count at zero and no further expiry occurs, even if control is rewritten with power and enable still set, until power or enable is cleared and set again. A timer started with a count of zero expires on its first step.
- R8: A control write stores bit 3 as written (writing 0 clears the flag, writing 1 sets it). An expiry in the same cycle as a control write leaves the flag set.
- R9: A period write also loads the same value into the count register.
- R10: The count register accepts writes while running; a count write in the same cycle as a count step takes precedence.
- R11: Changing the scale while running leaves the count unchanged; later steps use the new divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address within the block |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the request cycle |
| bus_err | output | 1 | Access rejected (size or alignment) |
| tmr_irq | output | 1 | One-cycle expiry pulse |

## Verification
The case that matters most is a control-register write in the very cycle the count runs out: the write carries a zero in the flag bit while expiry wants to set it. The bench enables a three-step one-shot with divisor one, waits two edges and lands a control write on the third, then reads control and expects the flag still set. A second collision puts a count write on an edge where a count step also happens, judged by the expiry arriving exactly two cycles later, which holds only if the written value won.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

   // word index of each register (address bits above the byte lane)
   localparam logic [1:0] IDX_CTRL  = 2'd0;
   localparam logic [1:0] IDX_PER   = 2'd1;
   localparam logic [1:0] IDX_SCALE = 2'd2;
   localparam logic [1:0] IDX_CNT   = 2'd3;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // bit 3 .. bit 0
   typedef struct packed {
      logic flag;
      logic reload;
      logic enable;
      logic power;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/ctm_regs.sv
module ctm_regs
   import ctm_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter int ADDR_W          = 4,
   parameter int SCALE_BITS      = 8,
   parameter bit KEEP_SCALE_WORD = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [1:0]            bus_size,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  bus_err,
   input  logic                  expire,
   input  logic [DATA_W-1:0]     count_q,
   output ctrl_t                 ctrl_q,
   output logic [DATA_W-1:0]     period_q,
   output logic [SCALE_BITS-1:0] scale_sel,
   output logic                  cnt_we,
   output logic [DATA_W-1:0]     cnt_wdata
);

   localparam int LANE_W = $clog2(DATA_W / 8);

   logic             acc_ok;
   logic             wr_any;
   logic [1:0]       idx;
   logic [DATA_W-1:0] scale_rd;
   ctrl_t            ctrl_d;

   assign idx    = bus_addr[LANE_W +: 2];
   assign acc_ok = (acc_size_e'(bus_size) == SZ_WORD) &&
                   (bus_addr[LANE_W-1:0] == '0);
   assign bus_err = bus_valid && !acc_ok;
   assign wr_any  = bus_valid && bus_write && acc_ok;

   // period write mirrors into the count; count write goes straight in
   assign cnt_we    = wr_any && ((idx == IDX_CNT) || (idx == IDX_PER));
   assign cnt_wdata = bus_wdata;

   // expiry has priority over a written zero in the flag bit
   always_comb begin
      ctrl_d      = ctrl_q;
      if (wr_any && (idx == IDX_CTRL))
         ctrl_d   = ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
      ctrl_d.flag = ctrl_d.flag | expire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
      end else begin
         ctrl_q <= ctrl_d;
         if (wr_any && (idx == IDX_PER))
            period_q <= bus_wdata;
      end
   end

   generate
      if (KEEP_SCALE_WORD) begin : g_scale_word
         logic [DATA_W-1:0] scale_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               scale_q <= '0;
            else if (wr_any && (idx == IDX_SCALE))
               scale_q <= bus_wdata;
         end
         assign scale_rd  = scale_q;
         assign scale_sel = scale_q[SCALE_BITS-1:0];
      end else begin : g_scale_narrow
         logic [SCALE_BITS-1:0] scale_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               scale_q <= '0;
            else if (wr_any && (idx == IDX_SCALE))
               scale_q <= bus_wdata[SCALE_BITS-1:0];
         end
         assign scale_rd  = DATA_W'(scale_q);
         assign scale_sel = scale_q;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_write && acc_ok) begin
         case (idx)
            IDX_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            IDX_PER:   bus_rdata = period_q;
            IDX_SCALE: bus_rdata = scale_rd;
            default:   bus_rdata = count_q;
         endcase
      end
   end

endmodule

// File: rtl/ctm_prescale.sv
module ctm_prescale #(
   parameter int SCALE_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_eff,
   input  logic [SCALE_BITS-1:0] scale_sel,
   output logic                  tick
);

   logic [SCALE_BITS-1:0] pre_q;

   // ">=" so a divisor lowered mid-phase steps at once instead of wrapping
   assign tick = run_eff && (pre_q >= scale_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (!run_eff || tick)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end

endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              reload,
   input  logic              tick,
   input  logic              cnt_we,
   input  logic [DATA_W-1:0] cnt_wdata,
   input  logic [DATA_W-1:0] period_q,
   output logic              run_eff,
   output logic              expire,
   output logic [DATA_W-1:0] count_q,
   output logic              irq_q
);

   logic halted_q;

   assign run_eff = run && !halted_q;
   assign expire  = tick && (count_q <= DATA_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         halted_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= expire;
         if (cnt_we)
            count_q <= cnt_wdata;
         else if (expire)
            count_q <= reload ? period_q : '0;
         else if (tick)
            count_q <= count_q - 1'b1;

         if (!run)
            halted_q <= 1'b0;
         else if (expire && !reload)
            halted_q <= 1'b1;
      end
   end

endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
   import ctm_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter int ADDR_W          = 4,
   parameter int SCALE_BITS      = 8,
   parameter bit KEEP_SCALE_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic              tmr_irq
);

   localparam int LANE_W = $clog2(DATA_W / 8);

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 16)
         $error("DATA_W must be a byte multiple of at least 16");
      if (ADDR_W != LANE_W + 2)
         $error("ADDR_W must cover exactly four word registers");
      if (SCALE_BITS < 1 || SCALE_BITS > DATA_W)
         $error("SCALE_BITS out of range");
   endgenerate

   ctrl_t                 ctrl_s;
   logic [DATA_W-1:0]     period_s;
   logic [DATA_W-1:0]     count_s;
   logic [SCALE_BITS-1:0] scale_s;
   logic                  cnt_we_s;
   logic [DATA_W-1:0]     cnt_wdata_s;
   logic                  run_s;
   logic                  run_eff_s;
   logic                  tick_s;
   logic                  expire_s;

   assign run_s = ctrl_s.power && ctrl_s.enable;

   ctm_regs #(
      .DATA_W          (DATA_W),
      .ADDR_W          (ADDR_W),
      .SCALE_BITS      (SCALE_BITS),
      .KEEP_SCALE_WORD (KEEP_SCALE_WORD)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .expire    (expire_s),
      .count_q   (count_s),
      .ctrl_q    (ctrl_s),
      .period_q  (period_s),
      .scale_sel (scale_s),
      .cnt_we    (cnt_we_s),
      .cnt_wdata (cnt_wdata_s)
   );

   ctm_prescale #(
      .SCALE_BITS (SCALE_BITS)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_eff   (run_eff_s),
      .scale_sel (scale_s),
      .tick      (tick_s)
   );

   ctm_counter #(
      .DATA_W (DATA_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_s),
      .reload    (ctrl_s.reload),
      .tick      (tick_s),
      .cnt_we    (cnt_we_s),
      .cnt_wdata (cnt_wdata_s),
      .period_q  (period_s),
      .run_eff   (run_eff_s),
      .expire    (expire_s),
      .count_q   (count_s),
      .irq_q     (tmr_irq)
   );

endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_err,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              tmr_irq,
   input logic              flag,
   input logic              run_eff,
   input logic [DATA_W-1:0] count_q,
   input logic [DATA_W-1:0] period_q
);

   localparam int              LANE_W   = $clog2(DATA_W / 8);
   localparam logic [ADDR_W-1:0] PER_ADDR = ADDR_W'(1 << LANE_W);

   // R5
   irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq |-> flag);

   // R3
   irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq |-> $past(run_eff));

   // R2
   err_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> $stable(period_q));

   // R9
   period_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && !bus_err && bus_addr == PER_ADDR)
      |=> (count_q == $past(bus_wdata)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_eff && !(bus_valid && bus_write)) |=> $stable(count_q));

endmodule

bind core_tick_timer ctm_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_err   (bus_err),
   .bus_wdata (bus_wdata),
   .tmr_irq   (tmr_irq),
   .flag      (ctrl_s.flag),
   .run_eff   (run_eff_s),
   .count_q   (count_s),
   .period_q  (period_s)
);

// File: tb/core_tick_timer_test.sv
`timescale 1ns/1ps
module core_tick_timer_test;

   localparam int DW = 32;
   localparam int AW = 4;
   localparam logic [AW-1:0] A_CTRL = 4'h0, A_PER = 4'h4, A_SCL = 4'h8, A_CNT = 4'hC;
   localparam logic [1:0] WORD = 2'd2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [1:0]    bus_size = WORD;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          bus_err;
   logic          tmr_irq;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   core_tick_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .tmr_irq(tmr_irq)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] sz = WORD);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
      @(posedge clk);
      #1;
      bus_valid = 1'b0; bus_write = 1'b0; bus_size = WORD;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic e,
                     input logic [1:0] sz = WORD);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
      #1;
      d = bus_rdata; e = bus_err;
      bus_valid = 1'b0; bus_size = WORD;
   endtask

   // posedges until tmr_irq is seen at a falling edge
   task automatic measure(output int cyc, input int lim);
      cyc = 0;
      do begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end while (!tmr_irq && cyc < lim);
   endtask

   task automatic quiet(input int cycles, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (tmr_irq) seen = 1'b1;
      end
      check(!seen, req, seen, 0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      logic e;
      int c;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, d, e); check(d == 0, "R1 ctrl reset", d, 0);
      rd(A_CNT, d, e);  check(d == 0, "R1 count reset", d, 0);
      check(!tmr_irq, "R5 irq reset", tmr_irq, 0);

      // R1 unused control bits read zero
      wr(A_CTRL, 32'hFFFF_FFF4);
      rd(A_CTRL, d, e); check(d == 32'h4, "R1 ctrl upper bits", d, 32'h4);
      wr(A_CTRL, 0);

      // R9 period mirrors into count
      wr(A_PER, 7);
      rd(A_CNT, d, e); check(d == 7, "R9 count mirror", d, 7);
      rd(A_PER, d, e); check(d == 7, "R1 period readback", d, 7);

      // R2 size and alignment rejection
      @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = A_PER; bus_size = 2'd0; bus_wdata = 32'h55;
      #1 check(bus_err, "R2 byte write err", bus_err, 1);
      @(posedge clk); #1 bus_valid = 0; bus_write = 0; bus_size = WORD;
      wr(4'h5, 32'h66);
      rd(A_PER, d, e); check(d == 7, "R2 rejected writes ignored", d, 7);
      rd(A_PER, d, e, 2'd1); check(e && d == 0, "R2 half read err", {e, d}, {1'b1, 32'h0});

      // R3 either bit alone does nothing
      wr(A_CTRL, 32'h1); quiet(20, "R3 power only irq");
      rd(A_CNT, d, e); check(d == 7, "R3 power only count", d, 7);
      wr(A_CTRL, 32'h2); quiet(20, "R3 enable only irq");
      rd(A_CNT, d, e); check(d == 7, "R3 enable only count", d, 7);
      wr(A_CTRL, 0);

      // R4/R5/R7 sweep of period and divisor, one-shot
      for (int n = 1; n <= 4; n++) begin
         for (int s = 0; s < 6; s++) begin
            int sv = (s < 4) ? s : ((s == 4) ? 32'h100 : 32'hFFFF_FF02);
            int dv = (sv & 8'hFF) + 1;
            wr(A_CTRL, 0);
            wr(A_PER, n);
            wr(A_SCL, sv);
            wr(A_CTRL, 32'h3);
            measure(c, 2000);
            check(c == n * dv, "R4 expiry delay", c, n * dv);
            rd(A_CTRL, d, e);
            check(d == 32'hB && !tmr_irq, "R5 flag set, pulse one cycle", {tmr_irq, d}, 32'hB);
            rd(A_CNT, d, e); check(d == 0, "R7 count parked at zero", d, 0);
            quiet(2 * n * dv + 4, "R7 no second expiry");
         end
      end

      // R7 rewrite with run still set stays halted; off then on restarts from zero count
      wr(A_SCL, 2);
      wr(A_CTRL, 32'h3); quiet(12, "R7 still halted");
      wr(A_CTRL, 0);
      wr(A_CTRL, 32'h3);
      measure(c, 100); check(c == 3, "R7 zero count expires on first step", c, 3);

      // R8 flag direct write
      wr(A_CTRL, 0);
      rd(A_CTRL, d, e); check(d == 0, "R8 write zero clears flag", d, 0);
      wr(A_CTRL, 32'h8);
      rd(A_CTRL, d, e); check(d == 32'h8, "R8 write one sets flag", d, 8);
      wr(A_CTRL, 0);

      // R6 auto-reload
      wr(A_PER, 3); wr(A_SCL, 1);
      wr(A_CTRL, 32'h7);
      measure(c, 100); check(c == 6, "R6 first expiry", c, 6);
      for (int k = 0; k < 3; k++) begin
         measure(c, 100); check(c == 6, "R6 reload interval", c, 6);
      end
      rd(A_CNT, d, e); check(d == 3, "R6 count reloaded", d, 3);
      wr(A_CTRL, 0);

      // R8 collision: control write with flag 0 on the expiry edge
      wr(A_PER, 3); wr(A_SCL, 0);
      wr(A_CTRL, 32'h3);
      repeat (2) @(posedge clk);
      wr(A_CTRL, 32'h3);
      rd(A_CTRL, d, e); check(d == 32'hB, "R8 expiry beats flag clear", d, 32'hB);
      wr(A_CTRL, 0);

      // R10 count write while running wins over a step
      wr(A_PER, 20);
      wr(A_CTRL, 32'h3);
      wr(A_CNT, 2);
      measure(c, 100); check(c == 2, "R10 count write while running", c, 2);
      wr(A_CTRL, 0);

      // R11 scale change keeps progress
      wr(A_PER, 10); wr(A_SCL, 0);
      wr(A_CTRL, 32'h3);
      wr(A_SCL, 1);
      rd(A_CNT, d, e); check(d == 9, "R11 count kept", d, 9);
      measure(c, 200); check(c == 18, "R11 new divisor used", c, 18);

      summary();
      $finish;
   end

endmodule